// File: doc/BRIEF.md
# FP Unit Enable and Vector-Trap Control

This block holds the 32-bit control word that switches the floating-point unit on and off, and it decides, instruction by instruction, whether an FP instruction has to be refused with a synchronous undefined-instruction trap. Software reads and writes the word through a plain register port. Only two fields are live: the unit enable and a sticky flag that records a refused short-vector operation. Every other bit reads as zero.

The issue stage presents a valid strobe, a decoded instruction class, a double-precision flag and the vector-length field taken from the FP status register. While the unit is disabled, every FP instruction except an access to this control word is refused. While it is enabled, a data-processing instruction with a nonzero vector length is refused and sets the sticky flag, because short vectors are not supported in hardware. Asynchronous FP exceptions are never raised. With the single-precision-only option, double-precision instructions leave the sticky flag alone and are not refused by the vector rule.

Top module: `fp_enable_trap`

## Requirements
- R1: After reset, `rd_data` reads 0x0000_0000 and `fp_enabled` is 0.
- R2: Bit 31 and bits 28 down to 0 of `rd_data` always read 0, whatever value is written. Bit 29 is the exception: it holds the sticky flag.
- R3: A write stores `wr_data[30]` as the enable. It is visible at `rd_data[30]` and on `fp_enabled` from the next cycle. A write also stores `wr_data[29]` into the sticky flag, unless R8 applies.
- R4: While enabled, a valid data-processing instruction (class 2'b00) with a nonzero `vec_len` raises `undef_trap` in the same cycle and sets `rd_data[29]` from the next cycle. With `vec_len` equal to 0 it does not trap.
- R5: With SP_ONLY=1, a valid double-precision instruction (`ins_dbl`=1) never sets `rd_data[29]` and is not trapped by the vector rule.
- R6: While disabled, any valid instruction whose class is not 2'b11 raises `undef_trap` in the same cycle and leaves `rd_data[29]` unchanged.
- R7: A valid control-word access (class 2'b11) never raises `undef_trap`.
- R8: A software write can clear the sticky flag. If the vector rule sets the flag in the same cycle as the write, the flag ends up set.
- R9: Load/store instructions (class 2'b01) and register-transfer instructions (class 2'b10) ignore `vec_len`. While enabled they neither trap nor set the flag.
- R10: `undef_trap` is 0 in any cycle in which `ins_valid` is 0, so each trap is a one-cycle pulse tied to its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| ins_valid | input | 1 | An FP instruction is issued this cycle |
| ins_class | input | 2 | 00 data-processing, 01 load/store, 10 register transfer, 11 control-word access |
| ins_dbl | input | 1 | Instruction is double precision |
| vec_len | input | LEN_W | Vector-length field from the FP status register |
| fp_enabled | output | 1 | FP unit enable qualifier |
| undef_trap | output | 1 | Synchronous undefined-instruction trap request |

## Verification
The assertions take the issue-side inputs as already decoded and stable for the whole cycle. The class code is one of the four listed values, and `ins_class`, `ins_dbl` and `vec_len` only matter while `ins_valid` is high. They also take it that software writes and instruction issue may coincide in any cycle. The stimulus changes inputs only on falling edges and always uses the defined class codes. It drives both a default instance and a single-precision-only instance with identical sequences, so the R5 exemption is seen against the unrestricted behaviour.

// File: rtl/fp_enable_trap.sv
module fp_enable_trap #(
  parameter int  LEN_W   = 3,
  parameter bit  SP_ONLY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             ins_valid,
  input  logic [1:0]       ins_class,
  input  logic             ins_dbl,
  input  logic [LEN_W-1:0] vec_len,
  output logic             fp_enabled,
  output logic             undef_trap
);

  localparam logic [1:0] CLS_DP   = 2'b00;
  localparam logic [1:0] CLS_CTRL = 2'b11;
  localparam int         EN_BIT   = 30;
  localparam int         FLG_BIT  = 29;

  logic en_q, flag_q;
  logic is_fp, dp_vector, exempt, vec_hit, off_hit;

  assign is_fp     = ins_valid && (ins_class != CLS_CTRL);
  assign exempt    = SP_ONLY && ins_dbl;
  assign dp_vector = (ins_class == CLS_DP) && (vec_len != '0);
  assign vec_hit   = ins_valid && en_q && dp_vector && !exempt;
  assign off_hit   = is_fp && !en_q;

  assign undef_trap = vec_hit || off_hit;
  assign fp_enabled = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= wr_data[EN_BIT];
      if (vec_hit)    flag_q <= 1'b1;
      else if (wr_en) flag_q <= wr_data[FLG_BIT];
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[EN_BIT]  = en_q;
    rd_data[FLG_BIT] = flag_q;
  end

endmodule

// File: rtl/fp_enable_trap_chk.sv
module fp_enable_trap_chk #(
  parameter int LEN_W   = 3,
  parameter bit SP_ONLY = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             ins_valid,
  input logic [1:0]       ins_class,
  input logic             ins_dbl,
  input logic [LEN_W-1:0] vec_len,
  input logic             fp_enabled,
  input logic             undef_trap
);

  logic vec_case;
  assign vec_case = ins_valid && fp_enabled && ins_class == 2'b00 &&
                    vec_len != '0 && !(SP_ONLY && ins_dbl);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] == 1'b0 && rd_data[28:0] == '0);

  assert_enable_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[30] == $past(wr_data[30]));

  assert_vec_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_case |-> undef_trap);

  assert_vec_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_case |=> rd_data[29]);

  assert_dbl_exempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (SP_ONLY && ins_valid && ins_dbl && !wr_en) |=> $stable(rd_data[29]));

  assert_off_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !fp_enabled && ins_class != 2'b11) |-> undef_trap);

  assert_off_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp_enabled && !wr_en) |=> $stable(rd_data[29]));

  assert_ctrl_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_class == 2'b11) |-> !undef_trap);

  assert_hw_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_case && wr_en) |=> rd_data[29]);

  assert_mem_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && fp_enabled && (ins_class == 2'b01 || ins_class == 2'b10)) |-> !undef_trap);

  assert_strobe_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |-> !undef_trap);

endmodule

bind fp_enable_trap fp_enable_trap_chk #(.LEN_W(LEN_W), .SP_ONLY(SP_ONLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .ins_valid(ins_valid), .ins_class(ins_class), .ins_dbl(ins_dbl), .vec_len(vec_len),
  .fp_enabled(fp_enabled), .undef_trap(undef_trap)
);

// File: tb/fp_enable_trap_tb.sv
`timescale 1ns/1ps
module fp_enable_trap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ins_valid = 1'b0;
  logic [1:0]  ins_class = 2'b00;
  logic        ins_dbl = 1'b0;
  logic [2:0]  vec_len = '0;
  logic [31:0] rd0, rd1;
  logic        en0, en1, trap0, trap1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fp_enable_trap #(.LEN_W(3), .SP_ONLY(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd0),
    .ins_valid(ins_valid), .ins_class(ins_class), .ins_dbl(ins_dbl), .vec_len(vec_len),
    .fp_enabled(en0), .undef_trap(trap0));

  fp_enable_trap #(.LEN_W(3), .SP_ONLY(1'b1)) u_dut_sp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd1),
    .ins_valid(ins_valid), .ins_class(ins_class), .ins_dbl(ins_dbl), .vec_len(vec_len),
    .fp_enabled(en1), .undef_trap(trap1));

  typedef struct {
    string       req;
    logic        t0, t1;
    logic [31:0] r0, r1;
  } item_t;

  item_t q[$];
  logic m_en[2];
  logic m_flg[2];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit we, logic [31:0] wd, bit v,
                      logic [1:0] cls, bit dbl, logic [2:0] len);
    item_t it;
    logic t[2];
    logic [31:0] r[2];
    @(negedge clk);
    wr_en = we; wr_data = wd; ins_valid = v; ins_class = cls; ins_dbl = dbl; vec_len = len;
    for (int d = 0; d < 2; d++) begin
      bit sp = (d == 1);
      bit set = v && m_en[d] && cls == 2'b00 && len != 0 && !(sp && dbl);
      t[d] = set || (v && !m_en[d] && cls != 2'b11);
      m_flg[d] = set ? 1'b1 : (we ? wd[29] : m_flg[d]);
      m_en[d]  = we ? wd[30] : m_en[d];
      r[d] = {1'b0, m_en[d], m_flg[d], 29'b0};
    end
    it.req = req; it.t0 = t[0]; it.t1 = t[1]; it.r0 = r[0]; it.r1 = r[1];
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; wr_data = '0; ins_valid = 0; ins_class = 2'b00; ins_dbl = 0; vec_len = '0;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(it.req, "trap", {31'b0, trap0}, {31'b0, it.t0});
        check(it.req, "trap sp", {31'b0, trap1}, {31'b0, it.t1});
        @(posedge clk);
        #1;
        check(it.req, "word", rd0, it.r0);
        check(it.req, "word sp", rd1, it.r1);
        check(it.req, "enable", {31'b0, en0}, {31'b0, it.r0[30]});
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_en = '{1'b0, 1'b0};
    m_flg = '{1'b0, 1'b0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "reset word", rd0, 32'h0);
    check("R1", "reset word sp", rd1, 32'h0);
    check("R1", "reset enable", {31'b0, en0}, 32'h0);

    step("R6", 0, 0, 1, 2'b00, 0, 3'd0);
    step("R6", 0, 0, 1, 2'b01, 0, 3'd0);
    step("R6", 0, 0, 1, 2'b00, 0, 3'd3);
    step("R7", 0, 0, 1, 2'b11, 0, 3'd0);
    step("R2", 1, 32'hFFFF_FFFF, 0, 2'b00, 0, 3'd0);
    step("R8", 1, 32'h4000_0000, 0, 2'b00, 0, 3'd0);
    step("R3", 1, 32'h9C00_1234, 0, 2'b00, 0, 3'd0);
    step("R3", 1, 32'h5C0F_FFFF, 0, 2'b00, 0, 3'd0);
    step("R4", 0, 0, 1, 2'b00, 0, 3'd0);
    step("R4", 0, 0, 1, 2'b00, 0, 3'd2);
    step("R8", 1, 32'h4000_0000, 0, 2'b00, 0, 3'd0);
    step("R5", 0, 0, 1, 2'b00, 1, 3'd1);
    step("R5", 0, 0, 1, 2'b00, 1, 3'd0);
    step("R8", 1, 32'h4000_0000, 1, 2'b00, 0, 3'd1);
    step("R8", 1, 32'h4000_0000, 0, 2'b00, 0, 3'd0);
    step("R9", 0, 0, 1, 2'b01, 0, 3'd7);
    step("R9", 0, 0, 1, 2'b10, 1, 3'd5);
    step("R10", 0, 0, 0, 2'b00, 0, 3'd3);
    step("R7", 0, 0, 1, 2'b11, 0, 3'd4);
    step("R4", 0, 0, 1, 2'b00, 0, 3'd7);
    step("R6", 1, 32'h2000_0000, 0, 2'b00, 0, 3'd0);
    step("R6", 0, 0, 1, 2'b00, 0, 3'd1);
    step("R6", 0, 0, 1, 2'b10, 0, 3'd0);
    step("R10", 0, 0, 0, 2'b01, 0, 3'd0);
    idle();
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule